// File: doc/BRIEF.md
# Interrupt Recognition Front End

This block sits between the external interrupt pins of a processor and its core. It watches three request inputs. The first is a maskable request, which is active high and level sensitive. The second is a non-maskable request, which acts on a rising edge. The third is an active-low system-management request. From these the block builds a single prioritised request towards the core, with a kind code and a vector. The core takes a request with a valid/accept handshake. Any stored state is used up only when the core accepts it. When the core executes a return-from-interrupt or a resume-from-management instruction, it sends a one-cycle pulse, and the pulse releases the matching block.

The non-maskable source and the edge-mode management source each run a four-state latch machine:

- `LS_IDLE` has nothing stored.
- `LS_WAIT_ACK` has one edge presented and waits for accept.
- `LS_IN_SERVICE` means a handler is running.
- `LS_SERVICE_HELD` means a handler is running and one further edge is stored.

Its transitions are:

- LS_IDLE to LS_WAIT_ACK when an edge arrives.
- LS_WAIT_ACK to LS_IN_SERVICE when the request is accepted, or to LS_SERVICE_HELD if an edge arrives in the same cycle as the accept.
- LS_IN_SERVICE to LS_SERVICE_HELD when an edge arrives.
- LS_IN_SERVICE to LS_IDLE when the return pulse arrives, or to LS_WAIT_ACK if the return pulse and an edge arrive together.
- LS_SERVICE_HELD to LS_WAIT_ACK when the return pulse arrives.

In level mode the management source does not use the latch machine. Instead a nesting counter tracks the handlers that are active, up to a parameterised limit.

Top module: `irq_front`

## Requirements
- R1: After reset, `req_valid_o` and `mgmt_active_o` are low, `req_kind_o` is 0, and no edge is stored.
- R2: The maskable pin is sampled once per clock. When the sampled level is high and `int_flag_i` is high, the block presents kind 1 with vector `ext_vec_i`. While `int_flag_i` is low, the maskable pin is not presented.
- R3: A rising edge on `nmi_pin_i` is presented as kind 2 with vector `NMI_VEC`, two clock edges after the pin rises. `int_flag_i` has no effect on it.
- R4: After a kind 2 request is accepted, no further kind 2 request is presented until `iret_i` pulses. At most one edge that arrives in that window is kept, and it is presented after the pulse. Any further edges in that window are dropped.
- R5: Priority is fixed. Kind 3 (management) wins over kind 2, and kind 2 wins over kind 1. A losing request stays presented and is not lost.
- R6: With `mgmt_level_mode_i` low, a falling edge on `mgmt_pin_n_i` is presented as kind 3 with vector `MGMT_VEC`. After it is accepted, further kind 3 requests are blocked until `rsm_i` pulses. At most one edge from that window is kept.
- R7: With `mgmt_level_mode_i` high, kind 3 is presented while the sampled pin is low. Each accept opens one more nesting level, and each `rsm_i` pulse closes one. No kind 3 request is presented while the nesting depth equals `MGMT_NEST_MAX`.
- R8: While `mgmt_en_i` is low, the management pin is ignored in both modes. A falling edge seen while the enable is low is not stored.
- R9: `mgmt_active_o` goes high in the cycle after a kind 3 request is accepted. It stays high until the `rsm_i` pulse that ends the last open management handler.
- R10: A presented kind 2 or kind 3 request stays presented until the core accepts it. Stored state changes only on accept or on a return pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_pin_i | input | 1 | Maskable request, active high, level sensitive |
| nmi_pin_i | input | 1 | Non-maskable request, rising-edge sensitive |
| mgmt_pin_n_i | input | 1 | Management request, active low |
| int_flag_i | input | 1 | Interrupt-enable flag from the core |
| mgmt_level_mode_i | input | 1 | 0: management input is edge latched; 1: management input is level sensitive and nested |
| mgmt_en_i | input | 1 | Enables recognition of the management input |
| iret_i | input | 1 | One-cycle pulse when a return-from-interrupt executes |
| rsm_i | input | 1 | One-cycle pulse when a resume-from-management executes |
| ext_vec_i | input | VEC_W | Vector reported for the maskable request |
| req_valid_o | output | 1 | A request is presented to the core |
| req_accept_i | input | 1 | The core takes the presented request |
| req_kind_o | output | 2 | Request kind: 0 none, 1 maskable, 2 non-maskable, 3 management |
| req_vec_o | output | VEC_W | Vector of the presented request |
| mgmt_active_o | output | 1 | A management handler is running |

## Verification
The bench builds the block with `MGMT_NEST_MAX` = 2 and `MGMT_VEC` = 0xA5, and leaves `VEC_W` and `NMI_VEC` at 8 and 0x02. The small nesting limit lets the bench reach the depth cap after two accepts in level mode. It also exercises a pop back below the cap. The distinct management vector shows that the vector mux follows the winning kind when all three sources are pending at once.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;

    typedef enum logic [1:0] {
        IRQ_NONE     = 2'd0,
        IRQ_MASKABLE = 2'd1,
        IRQ_NONMASK  = 2'd2,
        IRQ_MGMT     = 2'd3
    } irq_kind_e;

    typedef enum logic [1:0] {
        LS_IDLE         = 2'd0,
        LS_WAIT_ACK     = 2'd1,
        LS_IN_SERVICE   = 2'd2,
        LS_SERVICE_HELD = 2'd3
    } latch_state_e;

endpackage

// File: rtl/irq_pin_sampler.sv
module irq_pin_sampler #(
    parameter bit IDLE_LEVEL = 1'b0,
    parameter bit ACT_RISE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic edge_o
);

    logic smp_q;
    logic prev_q;

    // Two-stage history; reset to the idle level so no false edge appears.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q  <= IDLE_LEVEL;
            prev_q <= IDLE_LEVEL;
        end else begin
            smp_q  <= pin_i;
            prev_q <= smp_q;
        end
    end

    assign lvl_o = smp_q;

    generate
        if (ACT_RISE) begin : g_rise
            assign edge_o = smp_q & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~smp_q & prev_q;
        end
    endgenerate

endmodule

// File: rtl/irq_latch_fsm.sv
module irq_latch_fsm
    import irq_front_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic take_i,
    input  logic done_i,
    output logic req_o,
    output logic busy_o
);

    latch_state_e state_q;
    latch_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_IDLE: begin
                if (edge_i) state_d = LS_WAIT_ACK;
            end
            LS_WAIT_ACK: begin
                // a second edge while waiting is dropped; one during accept is kept
                if (take_i) state_d = edge_i ? LS_SERVICE_HELD : LS_IN_SERVICE;
            end
            LS_IN_SERVICE: begin
                if (done_i)      state_d = edge_i ? LS_WAIT_ACK : LS_IDLE;
                else if (edge_i) state_d = LS_SERVICE_HELD;
            end
            LS_SERVICE_HELD: begin
                if (done_i) state_d = LS_WAIT_ACK;
            end
            default: state_d = LS_IDLE;
        endcase
    end

    always_comb begin
        req_o  = 1'b0;
        busy_o = 1'b0;
        unique case (state_q)
            LS_IDLE:         begin req_o = 1'b0; busy_o = 1'b0; end
            LS_WAIT_ACK:     begin req_o = 1'b1; busy_o = 1'b0; end
            LS_IN_SERVICE:   begin req_o = 1'b0; busy_o = 1'b1; end
            LS_SERVICE_HELD: begin req_o = 1'b0; busy_o = 1'b1; end
            default:         begin req_o = 1'b0; busy_o = 1'b0; end
        endcase
    end

    // A request may only appear after an edge or a return pulse (R10)
    assert_req_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> ($past(edge_i) || $past(done_i)));

endmodule

// File: rtl/irq_nest_ctr.sv
module irq_nest_ctr #(
    parameter int NEST_MAX = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  logic pop_i,
    output logic full_o,
    output logic nonzero_o
);

    localparam int NEST_W = $clog2(NEST_MAX + 1);

    logic [NEST_W-1:0] depth_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
        end else if (push_i && !pop_i && !full_o) begin
            depth_q <= depth_q + 1'b1;
        end else if (pop_i && !push_i && nonzero_o) begin
            depth_q <= depth_q - 1'b1;
        end
    end

    assign full_o    = (depth_q == NEST_W'(NEST_MAX));
    assign nonzero_o = (depth_q != '0);

    // Depth never passes the configured nesting limit (R7)
    assert_depth_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= NEST_W'(NEST_MAX));

    // A resume with nothing open leaves the counter at zero (R7)
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && depth_q == '0) |=> (depth_q == '0));

endmodule

// File: rtl/irq_front.sv
module irq_front
    import irq_front_pkg::*;
#(
    parameter int               VEC_W         = 8,
    parameter logic [VEC_W-1:0] NMI_VEC       = 'h02,
    parameter logic [VEC_W-1:0] MGMT_VEC      = 'hF0,
    parameter int               MGMT_NEST_MAX = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_pin_i,
    input  logic             nmi_pin_i,
    input  logic             mgmt_pin_n_i,
    input  logic             int_flag_i,
    input  logic             mgmt_level_mode_i,
    input  logic             mgmt_en_i,
    input  logic             iret_i,
    input  logic             rsm_i,
    input  logic [VEC_W-1:0] ext_vec_i,
    output logic             req_valid_o,
    input  logic             req_accept_i,
    output logic [1:0]       req_kind_o,
    output logic [VEC_W-1:0] req_vec_o,
    output logic             mgmt_active_o
);

    logic      mask_lvl_q;
    logic      nmi_lvl;
    logic      nmi_edge;
    logic      mgmt_lvl_n;
    logic      mgmt_edge;
    logic      nmi_req;
    logic      nmi_busy;
    logic      cmp_req;
    logic      cmp_busy;
    logic      cmp_edge_ok;
    logic      nest_full;
    logic      nest_open;
    logic      lvl_req;
    logic      mgmt_req;
    logic      mask_req;
    logic      take_mgmt;
    irq_kind_e kind;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_lvl_q <= 1'b0;
        else        mask_lvl_q <= mask_pin_i;
    end

    irq_pin_sampler #(.IDLE_LEVEL(1'b0), .ACT_RISE(1'b1)) u_nmi_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (nmi_pin_i),
        .lvl_o  (nmi_lvl),
        .edge_o (nmi_edge)
    );

    irq_pin_sampler #(.IDLE_LEVEL(1'b1), .ACT_RISE(1'b0)) u_mgmt_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (mgmt_pin_n_i),
        .lvl_o  (mgmt_lvl_n),
        .edge_o (mgmt_edge)
    );

    irq_latch_fsm u_nmi_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (nmi_edge),
        .take_i (req_accept_i && kind == IRQ_NONMASK),
        .done_i (iret_i),
        .req_o  (nmi_req),
        .busy_o (nmi_busy)
    );

    assign cmp_edge_ok = mgmt_edge && mgmt_en_i && !mgmt_level_mode_i;
    assign take_mgmt   = req_accept_i && kind == IRQ_MGMT;

    irq_latch_fsm u_mgmt_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (cmp_edge_ok),
        .take_i (take_mgmt && cmp_req),
        .done_i (rsm_i),
        .req_o  (cmp_req),
        .busy_o (cmp_busy)
    );

    irq_nest_ctr #(.NEST_MAX(MGMT_NEST_MAX)) u_mgmt_nest (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (take_mgmt && !cmp_req),
        .pop_i     (rsm_i),
        .full_o    (nest_full),
        .nonzero_o (nest_open)
    );

    assign lvl_req  = mgmt_en_i && mgmt_level_mode_i && !mgmt_lvl_n && !nest_full;
    assign mgmt_req = cmp_req || lvl_req;
    assign mask_req = mask_lvl_q && int_flag_i;

    always_comb begin
        if (mgmt_req) begin
            kind      = IRQ_MGMT;
            req_vec_o = MGMT_VEC;
        end else if (nmi_req) begin
            kind      = IRQ_NONMASK;
            req_vec_o = NMI_VEC;
        end else if (mask_req) begin
            kind      = IRQ_MASKABLE;
            req_vec_o = ext_vec_i;
        end else begin
            kind      = IRQ_NONE;
            req_vec_o = '0;
        end
    end

    assign req_kind_o    = kind;
    assign req_valid_o   = (kind != IRQ_NONE);
    assign mgmt_active_o = cmp_busy || nest_open;

    // Maskable kind is never presented with the flag clear (R2)
    assert_mask_needs_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_kind_o == IRQ_MASKABLE) |-> int_flag_i);

    // Non-maskable request rises only after the sampled pin was high (R3)
    assert_nmi_from_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> ($past(nmi_lvl) || $past(iret_i)));

    // Accepted non-maskable request is not presented again next cycle (R4)
    assert_nmi_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept_i && req_kind_o == IRQ_NONMASK && !nmi_busy)
            |=> !(req_valid_o && req_kind_o == IRQ_NONMASK));

    // An unaccepted non-maskable request is never demoted (R10)
    assert_nmi_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_kind_o == IRQ_NONMASK && !req_accept_i)
            |=> (req_valid_o && (req_kind_o == IRQ_NONMASK || req_kind_o == IRQ_MGMT)));

    // Level-mode management request requires the enable (R8)
    assert_mgmt_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_kind_o == IRQ_MGMT && mgmt_level_mode_i && !cmp_req) |-> mgmt_en_i);

    // Accepted management request marks a running handler (R9)
    assert_mgmt_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept_i && req_kind_o == IRQ_MGMT && !rsm_i) |=> mgmt_active_o);

endmodule

// File: tb/irq_front_test.sv
module irq_front_test;

    logic       clk;
    logic       rst_n;
    logic       mask_pin;
    logic       nmi_pin;
    logic       mgmt_pin_n;
    logic       int_flag;
    logic       lvl_mode;
    logic       mgmt_en;
    logic       iret;
    logic       rsm;
    logic [7:0] ext_vec;
    logic       req_valid;
    logic       req_accept;
    logic [1:0] req_kind;
    logic [7:0] req_vec;
    logic       mgmt_active;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    irq_front #(
        .VEC_W         (8),
        .NMI_VEC       (8'h02),
        .MGMT_VEC      (8'hA5),
        .MGMT_NEST_MAX (2)
    ) uut (
        .clk               (clk),
        .rst_n             (rst_n),
        .mask_pin_i        (mask_pin),
        .nmi_pin_i         (nmi_pin),
        .mgmt_pin_n_i      (mgmt_pin_n),
        .int_flag_i        (int_flag),
        .mgmt_level_mode_i (lvl_mode),
        .mgmt_en_i         (mgmt_en),
        .iret_i            (iret),
        .rsm_i             (rsm),
        .ext_vec_i         (ext_vec),
        .req_valid_o       (req_valid),
        .req_accept_i      (req_accept),
        .req_kind_o        (req_kind),
        .req_vec_o         (req_vec),
        .mgmt_active_o     (mgmt_active)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic accept_one();
        req_accept = 1'b1;
        tick();
        req_accept = 1'b0;
    endtask

    task automatic pulse_iret();
        iret = 1'b1;
        tick();
        iret = 1'b0;
    endtask

    task automatic pulse_rsm();
        rsm = 1'b1;
        tick();
        rsm = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 valid after reset", req_valid, 0);
        chk("R1 kind after reset", req_kind, 0);
        chk("R1 active after reset", mgmt_active, 0);
    endtask

    task automatic t_mask();
        int_flag = 1'b1; mask_pin = 1'b1;
        tick();
        chk("R2 mask valid", req_valid, 1);
        chk("R2 mask kind", req_kind, 1);
        chk("R2 mask vector", req_vec, 8'h37);
        int_flag = 1'b0;
        #1;
        chk("R2 mask gated by flag", req_valid, 0);
        mask_pin = 1'b0; int_flag = 1'b1;
        tick();
        chk("R2 mask released", req_valid, 0);
        int_flag = 1'b0;
    endtask

    task automatic t_nmi_basic();
        nmi_pin = 1'b1;
        tick();
        chk("R3 nmi not yet", req_valid, 0);
        tick();
        chk("R3 nmi valid flag clear", req_valid, 1);
        chk("R3 nmi kind", req_kind, 2);
        chk("R3 nmi vector", req_vec, 8'h02);
        tick(); tick();
        chk("R10 nmi held until accept", req_kind, 2);
        accept_one();
        chk("R10 nmi consumed", req_valid, 0);
        nmi_pin = 1'b0;
        pulse_iret();
        tick();
        chk("R4 idle after return", req_valid, 0);
    endtask

    task automatic t_nmi_block();
        nmi_pin = 1'b1;
        tick(); tick();
        accept_one();
        nmi_pin = 1'b0; tick();
        nmi_pin = 1'b1; tick(); tick();
        chk("R4 edge blocked in service", req_valid, 0);
        nmi_pin = 1'b0; tick();
        nmi_pin = 1'b1; tick(); tick();
        chk("R4 extra edge blocked", req_valid, 0);
        pulse_iret();
        chk("R4 stored edge after return", req_valid, 1);
        chk("R4 stored edge kind", req_kind, 2);
        accept_one();
        pulse_iret();
        tick();
        chk("R4 only one edge kept", req_valid, 0);
        nmi_pin = 1'b0;
        tick(); tick();
    endtask

    task automatic t_priority();
        mgmt_en = 1'b1; lvl_mode = 1'b0;
        int_flag = 1'b1; mask_pin = 1'b1; nmi_pin = 1'b1; mgmt_pin_n = 1'b0;
        tick(); tick();
        chk("R5 mgmt wins", req_kind, 3);
        chk("R5 mgmt vector", req_vec, 8'hA5);
        accept_one();
        chk("R5 nmi next", req_kind, 2);
        chk("R9 active after mgmt accept", mgmt_active, 1);
        accept_one();
        chk("R5 mask last", req_kind, 1);
        mask_pin = 1'b0; int_flag = 1'b0;
        tick();
        chk("R5 all served", req_valid, 0);
        pulse_rsm();
        chk("R9 inactive after resume", mgmt_active, 0);
        pulse_iret();
        nmi_pin = 1'b0; mgmt_pin_n = 1'b1;
        tick(); tick();
    endtask

    task automatic t_mgmt_compat();
        mgmt_en = 1'b1; lvl_mode = 1'b0;
        mgmt_pin_n = 1'b0;
        tick(); tick();
        chk("R6 falling edge presented", req_kind, 3);
        accept_one();
        chk("R9 active in handler", mgmt_active, 1);
        mgmt_pin_n = 1'b1; tick();
        mgmt_pin_n = 1'b0; tick(); tick();
        chk("R6 blocked until resume", req_valid, 0);
        mgmt_pin_n = 1'b1; tick();
        mgmt_pin_n = 1'b0; tick(); tick();
        chk("R6 extra edge blocked", req_valid, 0);
        pulse_rsm();
        chk("R6 stored edge after resume", req_kind, 3);
        chk("R9 inactive between handlers", mgmt_active, 0);
        accept_one();
        pulse_rsm();
        chk("R6 only one edge kept", req_valid, 0);
        chk("R9 inactive at end", mgmt_active, 0);
        mgmt_pin_n = 1'b1;
        tick(); tick();
    endtask

    task automatic t_mgmt_disabled();
        mgmt_en = 1'b0; lvl_mode = 1'b0;
        mgmt_pin_n = 1'b0;
        tick(); tick();
        chk("R8 edge ignored when disabled", req_valid, 0);
        mgmt_en = 1'b1;
        tick();
        chk("R8 disabled edge not stored", req_valid, 0);
        mgmt_pin_n = 1'b1; mgmt_en = 1'b0;
        tick(); tick();
        lvl_mode = 1'b1; mgmt_pin_n = 1'b0;
        tick(); tick();
        chk("R8 level ignored when disabled", req_valid, 0);
    endtask

    task automatic t_mgmt_level();
        mgmt_en = 1'b1;
        tick();
        chk("R7 level request", req_kind, 3);
        accept_one();
        chk("R7 nested request", req_kind, 3);
        accept_one();
        chk("R7 capped at depth", req_valid, 0);
        chk("R9 active while nested", mgmt_active, 1);
        pulse_rsm();
        chk("R7 below cap again", req_kind, 3);
        mgmt_pin_n = 1'b1;
        tick();
        chk("R7 level released", req_valid, 0);
        chk("R9 still active one open", mgmt_active, 1);
        pulse_rsm();
        chk("R9 inactive after last resume", mgmt_active, 0);
    endtask

    initial begin
        rst_n = 1'b0; mask_pin = 1'b0; nmi_pin = 1'b0; mgmt_pin_n = 1'b1;
        int_flag = 1'b0; lvl_mode = 1'b0; mgmt_en = 1'b0;
        iret = 1'b0; rsm = 1'b0; ext_vec = 8'h37; req_accept = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_mask();
        t_nmi_basic();
        t_nmi_block();
        t_priority();
        t_mgmt_compat();
        t_mgmt_disabled();
        t_mgmt_level();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule